// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A single-port synchronous static memory with a fixed 32-bit word and a depth set by an address-width parameter. Every control input is sampled on the rising clock edge. A burst of up to four words starts from one of two address strobes. The host-side strobe always starts a read. The controller-side strobe starts a read or a write, depending on the write controls. Burst cycles that follow step through the four words of an aligned group, or hold the current address, under a step input. The walk through the group is either linear or interleaved.

Writes can cover single bytes, through a byte-write enable and four per-byte selects, or the whole word, through a whole-word write. The read path has one register, or a second output register chosen at run time. The data bus is modelled as separate input, output and drive-enable ports. The drive enable also follows an asynchronous output-enable pin. A sleep input freezes the block without losing its contents or its burst state.

Top module: `sbsram_core`

## Requirements
- R1: The chip is selected only when cs1_n=0, cs2=1 and cs3_n=0. A starting strobe seen while the chip is not selected is a deselect cycle. A deselect cycle makes no access and ends any burst, so later step cycles neither read nor write.
- R2: strobe_host_n=0 with cs1_n=0 and the chip selected loads addr and starts a read, whatever the write controls are. strobe_host_n is ignored while cs1_n=1.
- R3: strobe_ctl_n=0 loads addr and starts a burst when strobe_host_n is not taken. The burst is a write of the decoded bytes of data_in if any byte is requested, and a read otherwise.
- R4: With neither strobe taken and a burst active, burst_step_n=0 moves to the next burst address and burst_step_n=1 repeats the current one. In both cases the cycle reads or writes according to the byte decode.
- R5: The two low address bits of the n-th burst word (n=0..3, wrapping) are (start+n) mod 4 when order_linear=1, and start XOR n when order_linear=0. The upper bits keep the loaded address.
- R6: wr_all_n=0 writes all four bytes. With wr_all_n=1 and wr_byte_n=0, byte k (data bits 8k+7..8k) is written when byte_sel_n[k]=0. With wr_all_n=1 and wr_byte_n=1, no byte is written.
- R7: With piped=0, read data appears on data_out, with data_drive=1, in the cycle after the read cycle's rising edge.
- R8: With piped=1, read data appears one cycle later than with piped=0, after a second output register.
- R9: With piped=1, data_drive drops right after the edge that samples a deselect cycle, even while read data is still in the output register.
- R10: data_drive is 1 only while out_en_n=0, and it follows out_en_n without waiting for a clock edge. Write, idle and deselect cycles load nothing that drives the bus.
- R11: While sleep=1, no read or write happens and the bus is released from the next edge. Memory contents and burst state are kept, so a burst continues after sleep falls.
- R12: Synchronous active-high reset clears the burst and the output stages: data_drive=0, and step cycles access nothing until a strobe starts a burst. Memory contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Standby: freezes accesses and state |
| addr | input | AW | Word address loaded by a starting strobe |
| cs1_n | input | 1 | Chip select, active low; also gates the host strobe |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| strobe_host_n | input | 1 | Host-side strobe, starts a read burst |
| strobe_ctl_n | input | 1 | Controller-side strobe, starts a read or write burst |
| burst_step_n | input | 1 | 0 = next burst address, 1 = hold address |
| wr_all_n | input | 1 | Whole-word write, active low |
| wr_byte_n | input | 1 | Enables the per-byte selects, active low |
| byte_sel_n | input | 4 | Per-byte write selects, active low |
| order_linear | input | 1 | 1 = linear burst order, 0 = interleaved |
| piped | input | 1 | 1 = extra output register, 0 = flow-through |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| data_in | input | 32 | Write data |
| data_out | output | 32 | Read data |
| data_drive | output | 1 | High while the bus would be driven |

## Verification
A reference model in the bench follows the burst state, the memory and both output stages. Every cycle is compared with it under the stimulus below.

- Directed runs fill the memory with controller-strobe write bursts, then read it back with host-strobe bursts that also carry whole-word writes. The readback shows that a host strobe never writes.
- Single bursts start from odd offsets in each order mode and include held-address cycles. They separate the linear sequence from the interleaved one and stepping from holding.
- Partial-byte writes, starts while the chip is not selected, and step cycles after a deselect or a reset are read back. A wrong byte lane, or a write from a burst that had ended, shows up in the data.
- Reads in the pipelined mode are followed by a deselect or by sleep. The release cycle shows whether the fast disable is there. Toggling out_en_n between edges shows the asynchronous enable. A long random run mixes every control with mode changes.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int DW     = 32;
    localparam int BYTE_W = 8;
    localparam int NB     = DW / BYTE_W;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_DESEL = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e       kind;
        logic [NB-1:0]   wmask;
    } acc_t;

    // low address bits of burst word n starting from offset b
    function automatic logic [1:0] burst_offset(input logic lin,
                                                input logic [1:0] b,
                                                input logic [1:0] n);
        return lin ? 2'(b + n) : (b ^ n);
    endfunction

    // decoded byte request of the write controls
    function automatic logic [NB-1:0] byte_request(input logic all_n,
                                                   input logic byte_n,
                                                   input logic [NB-1:0] sel_n);
        if (!all_n)       return '1;
        else if (!byte_n) return ~sel_n;
        else              return '0;
    endfunction
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
    import sbs_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep,
    input  logic [AW-1:0] addr,
    input  logic          cs1_n,
    input  logic          cs2,
    input  logic          cs3_n,
    input  logic          strobe_host_n,
    input  logic          strobe_ctl_n,
    input  logic          burst_step_n,
    input  logic          wr_all_n,
    input  logic          wr_byte_n,
    input  logic [NB-1:0] byte_sel_n,
    input  logic          order_linear,
    output acc_t          acc,
    output logic [AW-1:0] eff_addr
);
    logic          act_q;
    logic [AW-1:0] base_q;
    logic [1:0]    cnt_q, cnt_d;
    logic          sel, host_take, start;
    logic [NB-1:0] req;

    always_comb begin
        sel       = !cs1_n && cs2 && !cs3_n;
        host_take = !strobe_host_n && !cs1_n;
        start     = host_take || !strobe_ctl_n;
        req       = byte_request(wr_all_n, wr_byte_n, byte_sel_n);
        cnt_d     = cnt_q + {1'b0, !burst_step_n};
        eff_addr  = {base_q[AW-1:2], burst_offset(order_linear, base_q[1:0], cnt_d)};
        acc.kind  = ACC_NONE;
        acc.wmask = '0;
        if (sleep) begin
            acc.kind = ACC_NONE;
        end else if (start && !sel) begin
            acc.kind = ACC_DESEL;
        end else if (start) begin
            eff_addr = addr;
            if (!host_take && |req) begin
                acc.kind  = ACC_WRITE;
                acc.wmask = req;
            end else begin
                acc.kind = ACC_READ;
            end
        end else if (act_q) begin
            if (|req) begin
                acc.kind  = ACC_WRITE;
                acc.wmask = req;
            end else begin
                acc.kind = ACC_READ;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (!sleep) begin
            if (start && !sel) begin
                act_q <= 1'b0;
            end else if (start) begin
                act_q  <= 1'b1;
                base_q <= addr;
                cnt_q  <= '0;
            end else if (act_q) begin
                cnt_q <= cnt_d;
            end
        end
    end
endmodule

// File: rtl/sbs_array.sv
module sbs_array
    import sbs_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  acc_t          acc,
    input  logic [AW-1:0] eff_addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (acc.kind == ACC_WRITE) begin
            for (int b = 0; b < NB; b++) begin
                if (acc.wmask[b])
                    mem[eff_addr][b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
            end
        end
        if (acc.kind == ACC_READ)
            rdata <= mem[eff_addr];
    end
endmodule

// File: rtl/sbs_outstage.sv
module sbs_outstage
    import sbs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep,
    input  acc_kind_e     kind,
    input  logic [DW-1:0] rdata,
    input  logic          piped,
    input  logic          out_en_n,
    output logic [DW-1:0] data_out,
    output logic          data_drive
);
    logic          v1_q, v2_q, dsel_q;
    logic [DW-1:0] d2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q   <= 1'b0;
            v2_q   <= 1'b0;
            dsel_q <= 1'b0;
        end else begin
            v1_q   <= (kind == ACC_READ);
            v2_q   <= v1_q && !sleep;
            dsel_q <= (kind == ACC_DESEL);
        end
    end

    always_ff @(posedge clk) d2_q <= rdata;

    always_comb begin
        data_out   = piped ? d2_q : rdata;
        data_drive = !out_en_n && (piped ? (v2_q && !dsel_q) : v1_q);
    end
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
    import sbs_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep,
    input  logic [AW-1:0] addr,
    input  logic          cs1_n,
    input  logic          cs2,
    input  logic          cs3_n,
    input  logic          strobe_host_n,
    input  logic          strobe_ctl_n,
    input  logic          burst_step_n,
    input  logic          wr_all_n,
    input  logic          wr_byte_n,
    input  logic [3:0]    byte_sel_n,
    input  logic          order_linear,
    input  logic          piped,
    input  logic          out_en_n,
    input  logic [31:0]   data_in,
    output logic [31:0]   data_out,
    output logic          data_drive
);
    acc_t          acc;
    logic [AW-1:0] eff_addr;
    logic [DW-1:0] rdata;

    sbs_ctrl #(.AW(AW)) u_ctrl (
        .clk(clk), .rst(rst), .sleep(sleep), .addr(addr),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .strobe_host_n(strobe_host_n), .strobe_ctl_n(strobe_ctl_n),
        .burst_step_n(burst_step_n), .wr_all_n(wr_all_n),
        .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n),
        .order_linear(order_linear), .acc(acc), .eff_addr(eff_addr)
    );

    sbs_array #(.AW(AW)) u_array (
        .clk(clk), .acc(acc), .eff_addr(eff_addr),
        .wdata(data_in), .rdata(rdata)
    );

    sbs_outstage u_out (
        .clk(clk), .rst(rst), .sleep(sleep), .kind(acc.kind),
        .rdata(rdata), .piped(piped), .out_en_n(out_en_n),
        .data_out(data_out), .data_drive(data_drive)
    );
endmodule

// File: rtl/sbs_core_chk.sv
module sbs_core_chk
    import sbs_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      sleep,
    input logic      piped,
    input logic      strobe_host_n,
    input logic      cs1_n,
    input logic      wr_all_n,
    input logic      wr_byte_n,
    input logic      data_drive,
    input acc_kind_e acc_kind
);
    AST_HOST_STROBE_READS: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !strobe_host_n && !cs1_n) |-> acc_kind != ACC_WRITE); // R2
    AST_NO_BYTES_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_all_n && wr_byte_n) |-> acc_kind != ACC_WRITE); // R6
    AST_SLEEP_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        sleep |-> acc_kind == ACC_NONE); // R11
    AST_SLEEP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !data_drive); // R11
    AST_DESEL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (acc_kind == ACC_DESEL) |=> !data_drive); // R9
    AST_FLOW_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (!piped && data_drive) |-> $past(acc_kind == ACC_READ)); // R7
    AST_PIPE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        (piped && data_drive) |-> $past(acc_kind == ACC_READ, 2)); // R8
endmodule

bind sbsram_core sbs_core_chk u_chk (
    .clk(clk), .rst(rst), .sleep(sleep), .piped(piped),
    .strobe_host_n(strobe_host_n), .cs1_n(cs1_n),
    .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
    .data_drive(data_drive), .acc_kind(acc.kind)
);

// File: tb/sbsram_core_tb.sv
module sbsram_core_tb;
    localparam int AW = 6;

    logic clk = 1'b0, rst = 1'b1, sleep = 1'b0;
    logic [AW-1:0] addr = '0;
    logic cs1_n = 1'b0, cs2 = 1'b1, cs3_n = 1'b0;
    logic strobe_host_n = 1'b1, strobe_ctl_n = 1'b1, burst_step_n = 1'b1;
    logic wr_all_n = 1'b1, wr_byte_n = 1'b1;
    logic [3:0] byte_sel_n = 4'hf;
    logic order_linear = 1'b1, piped = 1'b0, out_en_n = 1'b0;
    logic [31:0] data_in = '0;
    logic [31:0] data_out;
    logic data_drive;

    int nchk = 0, nfail = 0;
    bit done = 0;
    string cur_tag = "R12";

    // reference model state
    logic [31:0] mm [64];
    bit m_act = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0] m_cnt = '0;
    bit e1_v = 0, e2_v = 0, e_ds = 0;
    logic [31:0] e1_d, e2_d;

    always #10 clk = ~clk;

    sbsram_core #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .sleep(sleep), .addr(addr),
        .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .strobe_host_n(strobe_host_n), .strobe_ctl_n(strobe_ctl_n),
        .burst_step_n(burst_step_n), .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n),
        .byte_sel_n(byte_sel_n), .order_linear(order_linear), .piped(piped),
        .out_en_n(out_en_n), .data_in(data_in), .data_out(data_out),
        .data_drive(data_drive)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] offs(bit lin, logic [1:0] b, logic [1:0] n);
        return lin ? 2'(b + n) : (b ^ n);
    endfunction

    task automatic model_edge();
        bit sel, take, start;
        logic [3:0] req;
        logic [1:0] nc;
        logic [AW-1:0] ea;
        int kind; // 0 none, 1 read, 2 write, 3 deselect
        if (rst) begin
            m_act = 0; m_base = '0; m_cnt = '0; e1_v = 0; e2_v = 0; e_ds = 0;
            return;
        end
        sel   = !cs1_n && cs2 && !cs3_n;
        take  = !strobe_host_n && !cs1_n;
        start = take || !strobe_ctl_n;
        req   = !wr_all_n ? 4'hf : (!wr_byte_n ? ~byte_sel_n : 4'h0);
        nc    = m_cnt + {1'b0, !burst_step_n};
        ea    = {m_base[AW-1:2], offs(order_linear, m_base[1:0], nc)};
        kind  = 0;
        if (sleep) kind = 0;
        else if (start && !sel) kind = 3;
        else if (start) begin ea = addr; kind = (!take && |req) ? 2 : 1; end
        else if (m_act) kind = (|req) ? 2 : 1;
        e2_v = e1_v && !sleep;
        e2_d = e1_d;
        e1_v = (kind == 1);
        if (kind == 1) e1_d = mm[ea];
        if (kind == 2)
            for (int b = 0; b < 4; b++) if (req[b]) mm[ea][b*8 +: 8] = data_in[b*8 +: 8];
        e_ds = (kind == 3);
        if (!sleep) begin
            if (start && !sel) m_act = 0;
            else if (start) begin m_act = 1; m_base = addr; m_cnt = '0; end
            else if (m_act) m_cnt = nc;
        end
    endtask

    task automatic compare(string tag);
        bit eo;
        eo = !out_en_n && (piped ? (e2_v && !e_ds) : e1_v);
        chk(tag, {31'd0, data_drive}, {31'd0, eo}, "data_drive");
        if (eo) chk(tag, data_out, piped ? e2_d : e1_d, "data_out");
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(cur_tag);
    endtask

    task automatic idle_in();
        cs1_n = 0; cs2 = 1; cs3_n = 0; strobe_host_n = 1; strobe_ctl_n = 1;
        burst_step_n = 1; wr_all_n = 1; wr_byte_n = 1; byte_sel_n = 4'hf;
        sleep = 0; data_in = $urandom;
    endtask

    task automatic host_burst(logic [AW-1:0] a, int cont);
        idle_in(); strobe_host_n = 0; addr = a; wr_all_n = 0; step();
        for (int k = 0; k < cont; k++) begin idle_in(); burst_step_n = 0; step(); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL R12 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk("R12", {31'd0, data_drive}, 32'd0, "drive after reset");

        // fill memory with controller-strobe whole-word write bursts
        cur_tag = "R3";
        for (int a = 0; a < 64; a += 4) begin
            idle_in(); strobe_ctl_n = 0; addr = 6'(a); wr_all_n = 0; step();
            for (int k = 0; k < 3; k++) begin idle_in(); burst_step_n = 0; wr_all_n = 0; step(); end
        end
        // readback: host strobe with write asserted must read
        cur_tag = "R2"; piped = 0;
        for (int a = 0; a < 64; a += 4) host_burst(6'(a + 2), 3);
        idle_in(); step();

        // host strobe ignored while cs1_n high: burst continues
        host_burst(6'd40, 0);
        idle_in(); strobe_host_n = 0; cs1_n = 1; burst_step_n = 0; step();
        idle_in(); step();

        // interleaved order with held cycles
        cur_tag = "R5"; order_linear = 0;
        host_burst(6'd9, 0);
        idle_in(); burst_step_n = 0; step();
        cur_tag = "R4";
        idle_in(); burst_step_n = 1; step();
        idle_in(); burst_step_n = 0; step();
        cur_tag = "R5";
        idle_in(); burst_step_n = 0; step();
        idle_in(); burst_step_n = 0; step();
        order_linear = 1;
        host_burst(6'd23, 4);

        // partial byte writes, then read back
        cur_tag = "R6";
        idle_in(); strobe_ctl_n = 0; addr = 6'd20; wr_byte_n = 0; byte_sel_n = 4'b0101; step();
        idle_in(); burst_step_n = 0; wr_byte_n = 0; byte_sel_n = 4'b1110; step();
        idle_in(); burst_step_n = 0; wr_byte_n = 1; byte_sel_n = 4'b0000; step();
        host_burst(6'd20, 3);

        // deselect ends burst: following step with write stores nothing
        cur_tag = "R1";
        idle_in(); strobe_ctl_n = 0; addr = 6'd48; wr_all_n = 0; step();
        idle_in(); strobe_ctl_n = 0; addr = 6'd52; cs2 = 0; wr_all_n = 0; step();
        idle_in(); burst_step_n = 0; wr_all_n = 0; step();
        idle_in(); strobe_ctl_n = 0; addr = 6'd56; cs3_n = 1; step();
        idle_in(); burst_step_n = 0; wr_all_n = 0; step();
        host_burst(6'd48, 3);
        host_burst(6'd52, 3);

        // pipelined reads, async enable, fast release on deselect
        cur_tag = "R8"; piped = 1;
        host_burst(6'd12, 2);
        out_en_n = 1; #1;
        chk("R10", {31'd0, data_drive}, 32'd0, "drive with enable high");
        out_en_n = 0; #1;
        chk("R10", {31'd0, data_drive}, 32'd1, "drive with enable low");
        cur_tag = "R9";
        idle_in(); strobe_ctl_n = 0; cs1_n = 1; step();
        chk("R9", {31'd0, data_drive}, 32'd0, "release after deselect");
        idle_in(); step();
        cur_tag = "R7"; piped = 0;
        host_burst(6'd30, 3);
        idle_in(); step();

        // sleep keeps burst state and memory
        cur_tag = "R11";
        host_burst(6'd32, 0);
        for (int k = 0; k < 3; k++) begin
            idle_in(); sleep = 1; strobe_ctl_n = 0; addr = 6'd60; wr_all_n = 0; burst_step_n = 0; step();
            chk("R11", {31'd0, data_drive}, 32'd0, "drive during sleep");
        end
        idle_in(); burst_step_n = 0; step();
        idle_in(); burst_step_n = 0; step();
        host_burst(6'd60, 3);

        // reset mid-run: step write afterward stores nothing
        cur_tag = "R12";
        idle_in(); strobe_ctl_n = 0; addr = 6'd4; step();
        rst = 1; step(); rst = 0;
        chk("R12", {31'd0, data_drive}, 32'd0, "drive after second reset");
        idle_in(); burst_step_n = 0; wr_all_n = 0; step();
        host_burst(6'd0, 3);
        host_burst(6'd4, 3);

        // constrained random mix
        cur_tag = "R4";
        for (int i = 0; i < 4000; i++) begin
            idle_in();
            addr          = 6'($urandom);
            cs1_n         = ($urandom % 10) == 0;
            cs2           = ($urandom % 10) != 0;
            cs3_n         = ($urandom % 10) == 0;
            strobe_host_n = ($urandom % 5) != 0;
            strobe_ctl_n  = ($urandom % 5) != 0;
            burst_step_n  = $urandom;
            wr_all_n      = ($urandom % 4) != 0;
            wr_byte_n     = $urandom;
            byte_sel_n    = 4'($urandom);
            sleep         = ($urandom % 25) == 0;
            out_en_n      = ($urandom % 10) == 0;
            if (($urandom % 40) == 0) piped = ~piped;
            if (($urandom % 40) == 0) order_linear = ~order_linear;
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule